// File: doc/BRIEF.md
# Bus-Master Read Time-Slot Sequencer

This block runs one single-bit read time slot on a single-wire open-drain bus, acting as the bus master. A start request opens the slot. The master pulls the line low for a short programmed time and then releases it. If the slave holds the line low past that release, it is returning a 0. If the line rises as soon as the master lets go, the slave is returning a 1.

The block samples the line at a programmed cycle. That cycle is meant to sit just before the latest instant at which sampling is still valid. The block then waits out the rest of the slot and a recovery period whose length is programmed separately, so the recovery can be stretched for buses that carry many devices. During recovery the block can optionally enable a strong pullup. A one-cycle done pulse closes the transaction.

All four timings are cycle counts. They are captured when a slot starts, so software may change them at any time. The line input passes through a two-flop synchronizer before it is used.

Top module: `owm_read_slot`

## Requirements
- R1: While reset is asserted and after it is released, `drive_low_o`, `pullup_o`, `done_o`, `busy_o` and `bit_o` are all 0.
- R2: A `start_i` seen while idle starts the slot on the next cycle, which is slot cycle 0. `drive_low_o` is 1 exactly on slot cycles 0 to E-1, where E = max(`low_cyc_i`, 1).
- R3: The last slot cycle has index max(max(`slot_cyc_i`,1)-1, `samp_cyc_i`, E), so at least one cycle with the line released always follows the low phase.
- R4: On slot cycle `samp_cyc_i` the block captures the synchronized line into `bit_o`. Because of the two-flop synchronizer, that value is the `line_i` level during slot cycle `samp_cyc_i`-2 (for `samp_cyc_i` ≥ 2). The value is visible from the next cycle and is held until the next sample.
- R5: After the last slot cycle come exactly `rec_cyc_i` recovery cycles with `drive_low_o`=0. `pullup_o` is 1 on every recovery cycle when `pullup_en_i` was 1 at start, and 0 on every recovery cycle otherwise.
- R6: `drive_low_o` and `pullup_o` are never 1 in the same cycle.
- R7: `done_o` is 1 for exactly one cycle, directly after the last recovery cycle (or directly after the last slot cycle when there is no recovery), and the block is idle on the cycle after that. `busy_o` is 1 from slot cycle 0 through the done cycle.
- R8: A `start_i` that arrives while `busy_o` is 1 is ignored. It does not restart, stretch or requeue a slot.
- R9: The timing inputs and `pullup_en_i` are captured at start. Changing them during a slot has no effect on that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one read slot |
| low_cyc_i | input | 16 | Master low time in cycles (0 treated as 1) |
| samp_cyc_i | input | 16 | Slot cycle at which the line is sampled |
| slot_cyc_i | input | 16 | Total slot length in cycles |
| rec_cyc_i | input | 16 | Recovery length in cycles |
| pullup_en_i | input | 1 | Enable strong pullup during recovery |
| line_i | input | 1 | Raw bus line level |
| drive_low_o | output | 1 | Open-drain pull-down enable |
| pullup_o | output | 1 | Strong pullup enable |
| bit_o | output | 1 | Last sampled data bit |
| busy_o | output | 1 | Slot or recovery in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps the master low time, the sample cycle, the slot length, the recovery length and the pullup option. For every combination, a modelled slave holds the line low for varying lengths: none, shorter than the sample point, exactly reaching it, and well past it. The slave hold lengths that end just before or just after the sample point separate a correct two-cycle synchronizer lag from an off-by-one sample position. Zero low-time and zero or short slot lengths exercise the clamping rules. During some slots the bench deliberately toggles `start_i` and scrambles the timing inputs, which shows that no slot is restarted or re-timed in mid-flight.

// File: rtl/rs_pkg.sv
package rs_pkg;
  parameter int RS_CW = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SLOT = 2'd1,
    ST_REC  = 2'd2,
    ST_DONE = 2'd3
  } rs_state_e;

  // Effective master low time: never shorter than one cycle.
  function automatic logic [RS_CW-1:0] eff_low(input logic [RS_CW-1:0] low);
    return (low == '0) ? RS_CW'(1) : low;
  endfunction

  // Index of the final slot cycle after clamping.
  function automatic logic [RS_CW-1:0] slot_last(input logic [RS_CW-1:0] low,
                                                 input logic [RS_CW-1:0] samp,
                                                 input logic [RS_CW-1:0] slot);
    logic [RS_CW-1:0] l;
    l = (slot == '0) ? '0 : slot - RS_CW'(1);
    if (samp > l) l = samp;
    if (eff_low(low) > l) l = eff_low(low);
    return l;
  endfunction
endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= RST_VAL;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rs_seq.sv
module rs_seq
  import rs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [RS_CW-1:0] low_cyc_i,
  input  logic [RS_CW-1:0] samp_cyc_i,
  input  logic [RS_CW-1:0] slot_cyc_i,
  input  logic [RS_CW-1:0] rec_cyc_i,
  input  logic             pullup_en_i,
  input  logic             line_s_i,
  output logic             drive_low_o,
  output logic             pullup_o,
  output logic             bit_o,
  output logic             busy_o,
  output logic             done_o
);
  rs_state_e        state_q;
  logic [RS_CW-1:0] k_q;
  logic [RS_CW-1:0] low_q, samp_q, last_q, rec_q;
  logic             pu_q, bit_q;

  // Named events for the assertions.
  wire accept_ev   = (state_q == ST_IDLE) && start_i;
  wire slot_begin  = (state_q == ST_SLOT) && (k_q == '0);
  wire slot_end_ev = (state_q == ST_SLOT) && (k_q == last_q);
  wire rec_end_ev  = (state_q == ST_REC)  && (k_q == rec_q - RS_CW'(1));
  wire sample_ev   = (state_q == ST_SLOT) && (k_q == samp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      k_q     <= '0;
      low_q   <= RS_CW'(1);
      samp_q  <= '0;
      last_q  <= RS_CW'(1);
      rec_q   <= '0;
      pu_q    <= 1'b0;
      bit_q   <= 1'b0;
    end else begin
      if (sample_ev) bit_q <= line_s_i;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SLOT;
          k_q     <= '0;
          low_q   <= eff_low(low_cyc_i);
          samp_q  <= samp_cyc_i;
          last_q  <= slot_last(low_cyc_i, samp_cyc_i, slot_cyc_i);
          rec_q   <= rec_cyc_i;
          pu_q    <= pullup_en_i;
        end
        ST_SLOT: begin
          if (slot_end_ev) begin
            k_q     <= '0;
            state_q <= (rec_q == '0) ? ST_DONE : ST_REC;
          end else begin
            k_q <= k_q + RS_CW'(1);
          end
        end
        ST_REC: begin
          if (rec_end_ev) state_q <= ST_DONE;
          else            k_q <= k_q + RS_CW'(1);
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign drive_low_o = (state_q == ST_SLOT) && (k_q < low_q);
  assign pullup_o    = (state_q == ST_REC) && pu_q;
  assign bit_o       = bit_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);

  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_low_o && pullup_o));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  assert_begin_from_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_begin |-> $past(accept_ev));

  assert_counter_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLOT) |-> (k_q <= last_q));

  assert_low_leads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_begin |-> drive_low_o);

  assert_release_before_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end_ev |-> !drive_low_o);
endmodule

// File: rtl/owm_read_slot.sv
module owm_read_slot
  import rs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [RS_CW-1:0] low_cyc_i,
  input  logic [RS_CW-1:0] samp_cyc_i,
  input  logic [RS_CW-1:0] slot_cyc_i,
  input  logic [RS_CW-1:0] rec_cyc_i,
  input  logic             pullup_en_i,
  input  logic             line_i,
  output logic             drive_low_o,
  output logic             pullup_o,
  output logic             bit_o,
  output logic             busy_o,
  output logic             done_o
);
  logic line_s;

  rs_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  rs_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .low_cyc_i   (low_cyc_i),
    .samp_cyc_i  (samp_cyc_i),
    .slot_cyc_i  (slot_cyc_i),
    .rec_cyc_i   (rec_cyc_i),
    .pullup_en_i (pullup_en_i),
    .line_s_i    (line_s),
    .drive_low_o (drive_low_o),
    .pullup_o    (pullup_o),
    .bit_o       (bit_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );
endmodule

// File: tb/tb_owm_read_slot.sv
module tb_owm_read_slot;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] low_cyc_i = '0, samp_cyc_i = '0, slot_cyc_i = '0, rec_cyc_i = '0;
  logic        pullup_en_i = 1'b0;
  logic        line_i = 1'b1;
  logic        drive_low_o, pullup_o, bit_o, busy_o, done_o;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  owm_read_slot dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .low_cyc_i(low_cyc_i), .samp_cyc_i(samp_cyc_i), .slot_cyc_i(slot_cyc_i),
    .rec_cyc_i(rec_cyc_i), .pullup_en_i(pullup_en_i), .line_i(line_i),
    .drive_low_o(drive_low_o), .pullup_o(pullup_o), .bit_o(bit_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // One read slot with a modelled slave holding the line for hold cycles.
  task automatic run_slot(input int low, input int samp, input int slot, input int rec,
                          input bit spu, input int hold, input bit poke);
    int e, last, low_line, total;
    bit exp_bit;
    e = (low == 0) ? 1 : low;
    last = imax(imax(((slot == 0) ? 1 : slot) - 1, samp), e);
    low_line = imax(e, hold);
    exp_bit = ((samp - 2) < low_line) ? 1'b0 : 1'b1;
    total = last + 1 + rec;
    @(negedge clk);
    low_cyc_i = 16'(low); samp_cyc_i = 16'(samp); slot_cyc_i = 16'(slot);
    rec_cyc_i = 16'(rec); pullup_en_i = spu; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R9: scramble the configuration once the slot has started
    low_cyc_i = 16'd40; samp_cyc_i = 16'd1; slot_cyc_i = 16'd3;
    rec_cyc_i = 16'd50; pullup_en_i = ~spu;
    for (int k = 0; k <= total; k++) begin
      line_i = (k < low_line) ? 1'b0 : 1'b1;
      start_i = (poke && (k == 1 || k == total)) ? 1'b1 : 1'b0;  // R8
      chk(busy_o === 1'b1, "R7 busy", busy_o, 1);
      if (k <= last) begin
        chk(drive_low_o === (k < e), "R2 drive_low", drive_low_o, (k < e));
        chk(pullup_o === 1'b0, "R6 pullup in slot", pullup_o, 0);
        chk(done_o === 1'b0, "R3 done in slot", done_o, 0);
      end else if (k < total) begin
        chk(drive_low_o === 1'b0, "R5 drive in recovery", drive_low_o, 0);
        chk(pullup_o === spu, "R5 pullup", pullup_o, spu);
        chk(done_o === 1'b0, "R5 done in recovery", done_o, 0);
      end else begin
        chk(done_o === 1'b1, "R7 done", done_o, 1);
        chk(drive_low_o === 1'b0 && pullup_o === 1'b0, "R6 outputs at done",
            {drive_low_o, pullup_o}, 0);
        chk(bit_o === exp_bit, "R4 sampled bit", bit_o, exp_bit);
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    line_i = 1'b1;
    chk(busy_o === 1'b0, "R7 idle after done", busy_o, 0);
    chk(done_o === 1'b0, "R7 done width", done_o, 0);
    @(negedge clk);
    chk(drive_low_o === 1'b0 && busy_o === 1'b0, "R8 no restart",
        {drive_low_o, busy_o}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(drive_low_o === 1'b0 && pullup_o === 1'b0 && done_o === 1'b0 && busy_o === 1'b0,
        "R1 in reset", {drive_low_o, pullup_o, done_o, busy_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bit_o === 1'b0 && busy_o === 1'b0, "R1 after reset", {bit_o, busy_o}, 0);
    for (int lo = 0; lo < 4; lo++)
      for (int sp = 2; sp < 7; sp++)
        for (int si = 0; si < 3; si++)
          for (int rc = 0; rc < 3; rc++)
            for (int hi = 0; hi < 4; hi++)
              for (int pu = 0; pu < 2; pu++) begin
                int sl, rv, hd;
                sl = si * 4;
                rv = (rc == 2) ? 3 : rc;
                hd = (hi == 0) ? 0 : ((hi == 1) ? 3 : ((hi == 2) ? 5 : 8));
                run_slot(lo, sp, sl, rv, pu[0], hd, (hi == 1));
              end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule